// File: doc/BRIEF.md
# Serial Port Control Word and Channel Steering

This block holds the control word of a serial port and steers bytes between the host, the receive line and the two FIFOs that sit behind it. The control word yields an enable for each direction, self-clearing reset pulses for the receive and transmit sides, a pulse that restarts the receive timeout, and a level that asks the line driver to hold a break.

A two-bit channel mode field, carried in a wider mode word, picks one of four routings:

- **Normal:** the host feeds the transmit side and the line feeds the receive FIFO.
- **Auto-echo:** every line byte is both received and sent back out.
- **Local loopback:** host bytes go straight into the receive FIFO.
- **Remote loopback:** line bytes are only sent back out.

A break seen on the line puts a zero byte into the receive FIFO whatever the mode. Shift registers, baud generation and the FIFOs themselves sit outside the block. The block drives only their push strobes and data.

Top module: `uart_chan_router`

## Requirements
- R1: After reset the control readback is 0x128, the channel mode is 0 (normal), both direction enables are 0, and no push, pulse or break request is active.
- R2: Control bit 2 enables receive and bit 3 disables it. Bit 4 enables transmit and bit 5 disables it. A direction is enabled only while its enable bit is 1 and its disable bit is 0, so disable wins.
- R3: A control write with bit 0 (receive reset), bit 1 (transmit reset) or bit 6 (timeout restart) set raises the matching pulse for exactly the one cycle after the write. Bits 0 and 1 read back as 0 afterwards, and every other bit reads back as written.
- R4: The break request is high exactly while control bit 7 (start break) is 1 and bit 8 (stop break) is 0.
- R5: In mode 0 (normal), a host byte is pushed to transmit and a line byte is pushed to the receive FIFO.
- R6: In mode 1 (echo), a line byte is pushed both to the receive FIFO and to transmit, and a host byte is discarded.
- R7: In mode 2 (local loopback), a host byte is pushed to the receive FIFO, and a line byte is discarded.
- R8: In mode 3 (remote loopback), a line byte is pushed to transmit only, and a host byte is discarded.
- R9: A push to a direction happens only when that direction is enabled. A byte bound for a disabled direction is dropped without trace.
- R10: A line break pushes a byte of value 0 into the receive FIFO in every mode, provided receive is enabled. It takes priority over any byte bound for the receive FIFO in the same cycle, and that byte is dropped.
- R11: The channel mode is taken from bits [9:8] of a mode-word write. All other bits of the mode word have no effect on routing.
- R12: Push strobes and data appear one cycle after the input strobe. They use the mode and enables that were in force before any register write made in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_we | input | 1 | Control word write strobe |
| ctrl_wdata | input | CTRL_W | Control word write data |
| mode_we | input | 1 | Mode word write strobe |
| mode_wdata | input | MODE_W | Mode word write data; channel mode in [9:8] |
| host_wr | input | 1 | Host data-register write strobe |
| host_wdata | input | DATA_W | Host byte |
| line_vld | input | 1 | Received line byte valid |
| line_data | input | DATA_W | Received line byte |
| line_brk | input | 1 | Received break pulse |
| ctrl_rdata | output | CTRL_W | Control word readback |
| chan_mode | output | 2 | Current channel mode |
| rx_en | output | 1 | Receive direction enabled |
| tx_en | output | 1 | Transmit direction enabled |
| brk_req | output | 1 | Hold break on the line |
| rx_rst_pls | output | 1 | One-cycle receive reset |
| tx_rst_pls | output | 1 | One-cycle transmit reset |
| tout_rst_pls | output | 1 | One-cycle receive-timeout restart |
| rx_push | output | 1 | Receive FIFO push |
| rx_push_data | output | DATA_W | Receive FIFO push data |
| tx_push | output | 1 | Transmit push |
| tx_push_data | output | DATA_W | Transmit push data |

## Verification
The bench targets several corner cases, each paired with the failure it would expose.

- **Enable and disable both set:** a design that honoured enable over disable would push bytes that must vanish.
- **Break coinciding with a line or loopback byte:** a wrong priority would deliver the data byte instead of zero, or deliver two pushes.
- **Mode or control write landing in the same cycle as a byte:** this exposes a design that routes with the new settings a cycle early.
- **Mode word with every bit outside [9:8] set:** this catches a mis-sliced field.
- **Reset bits held in the register:** a design that kept them stored would repeat the pulses or show them in the readback.

// File: rtl/uart_chan_pkg.sv
package uart_chan_pkg;

   typedef enum logic [1:0] {
      CHM_NORMAL = 2'd0,
      CHM_ECHO   = 2'd1,
      CHM_LLOOP  = 2'd2,
      CHM_RLOOP  = 2'd3
   } chan_mode_e;

   // control word bit positions (behaviour depends on them)
   localparam int CB_RX_RST  = 0;
   localparam int CB_TX_RST  = 1;
   localparam int CB_RX_EN   = 2;
   localparam int CB_RX_DIS  = 3;
   localparam int CB_TX_EN   = 4;
   localparam int CB_TX_DIS  = 5;
   localparam int CB_TO_RST  = 6;
   localparam int CB_BRK_GO  = 7;
   localparam int CB_BRK_END = 8;
   localparam int CTRL_BITS  = 9;

   // direction index: 0 receive, 1 transmit
   localparam int DIR_RX = 0;
   localparam int DIR_TX = 1;

endpackage

// File: rtl/uart_ctrl_reg.sv
module uart_ctrl_reg
   import uart_chan_pkg::*;
#(
   parameter int CTRL_W = CTRL_BITS,
   parameter logic [CTRL_W-1:0] RST_VAL = CTRL_W'(9'h128)
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctrl_we,
   input  logic [CTRL_W-1:0] ctrl_wdata,
   output logic [CTRL_W-1:0] ctrl_q,
   output logic [1:0]        dir_en,
   output logic [1:0]        dir_rst_pls,
   output logic              tout_rst_pls,
   output logic              brk_req
);

   localparam logic [CTRL_W-1:0] SELF_CLR =
      CTRL_W'((1 << CB_RX_RST) | (1 << CB_TX_RST));

   if (CTRL_W < CTRL_BITS) begin : g_bad_width
      $error("uart_ctrl_reg: CTRL_W too small for control fields");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q       <= RST_VAL & ~SELF_CLR;
         tout_rst_pls <= 1'b0;
      end else begin
         tout_rst_pls <= ctrl_we & ctrl_wdata[CB_TO_RST];
         if (ctrl_we) ctrl_q <= ctrl_wdata & ~SELF_CLR;
      end
   end

   for (genvar d = 0; d < 2; d++) begin : g_dir
      localparam int EN_B  = (d == DIR_RX) ? CB_RX_EN  : CB_TX_EN;
      localparam int DIS_B = (d == DIR_RX) ? CB_RX_DIS : CB_TX_DIS;
      localparam int RST_B = (d == DIR_RX) ? CB_RX_RST : CB_TX_RST;

      assign dir_en[d] = ctrl_q[EN_B] & ~ctrl_q[DIS_B];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) dir_rst_pls[d] <= 1'b0;
         else        dir_rst_pls[d] <= ctrl_we & ctrl_wdata[RST_B];
      end

      // R3: a reset pulse only follows a write carrying its bit
      assert_rst_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
         dir_rst_pls[d] |-> $past(ctrl_we && ctrl_wdata[RST_B]));
   end

   assign brk_req = ctrl_q[CB_BRK_GO] & ~ctrl_q[CB_BRK_END];

   assert_brk_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(brk_req) |-> $past(ctrl_we));

   assert_rst_once_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (tout_rst_pls && !$past(ctrl_we, 2)) |=> !tout_rst_pls || $past(ctrl_we));

endmodule

// File: rtl/uart_path_steer.sv
module uart_path_steer
   import uart_chan_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int MODE_W   = 12,
   parameter int MODE_LSB = 8
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_we,
   input  logic [MODE_W-1:0] mode_wdata,
   input  logic [1:0]        dir_en,
   input  logic              host_wr,
   input  logic [DATA_W-1:0] host_wdata,
   input  logic              line_vld,
   input  logic [DATA_W-1:0] line_data,
   input  logic              line_brk,
   output chan_mode_e        mode_q,
   output logic              rx_push,
   output logic [DATA_W-1:0] rx_push_data,
   output logic              tx_push,
   output logic [DATA_W-1:0] tx_push_data
);

   localparam int MODE_MSB = MODE_LSB + 1;

   if (MODE_MSB >= MODE_W) begin : g_bad_mode
      $error("uart_path_steer: mode field outside mode word");
   end
   if (DATA_W < 5 || DATA_W > 9) begin : g_bad_data
      $error("uart_path_steer: DATA_W must be 5..9");
   end

   logic              host_to_rx, host_to_tx, line_to_rx, line_to_tx;
   logic              rx_nxt, tx_nxt;
   logic [DATA_W-1:0] rx_dnxt, tx_dnxt;

   always_comb begin
      host_to_rx = (mode_q == CHM_LLOOP);
      host_to_tx = (mode_q == CHM_NORMAL);
      line_to_rx = (mode_q == CHM_NORMAL) || (mode_q == CHM_ECHO);
      line_to_tx = (mode_q == CHM_ECHO)   || (mode_q == CHM_RLOOP);

      rx_nxt  = 1'b0;
      rx_dnxt = '0;
      if (dir_en[DIR_RX]) begin
         if (line_brk) begin
            rx_nxt = 1'b1;
         end else if (host_wr && host_to_rx) begin
            rx_nxt  = 1'b1;
            rx_dnxt = host_wdata;
         end else if (line_vld && line_to_rx) begin
            rx_nxt  = 1'b1;
            rx_dnxt = line_data;
         end
      end

      tx_nxt  = 1'b0;
      tx_dnxt = '0;
      if (dir_en[DIR_TX]) begin
         if (host_wr && host_to_tx) begin
            tx_nxt  = 1'b1;
            tx_dnxt = host_wdata;
         end else if (line_vld && line_to_tx) begin
            tx_nxt  = 1'b1;
            tx_dnxt = line_data;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q       <= CHM_NORMAL;
         rx_push      <= 1'b0;
         rx_push_data <= '0;
         tx_push      <= 1'b0;
         tx_push_data <= '0;
      end else begin
         if (mode_we) mode_q <= chan_mode_e'(mode_wdata[MODE_MSB:MODE_LSB]);
         rx_push      <= rx_nxt;
         rx_push_data <= rx_dnxt;
         tx_push      <= tx_nxt;
         tx_push_data <= tx_dnxt;
      end
   end

   assert_rx_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rx_push |-> $past(dir_en[DIR_RX]));
   assert_tx_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
      tx_push |-> $past(dir_en[DIR_TX]));
   assert_brk_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (line_brk && dir_en[DIR_RX]) |=> (rx_push && rx_push_data == '0));
   assert_remote_norx_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_push && $past(mode_q) == CHM_RLOOP) |-> $past(line_brk));
   assert_tx_source_R12: assert property (@(posedge clk) disable iff (!rst_n)
      tx_push |-> $past(host_wr || line_vld));

endmodule

// File: rtl/uart_chan_router.sv
module uart_chan_router
   import uart_chan_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int CTRL_W   = CTRL_BITS,
   parameter int MODE_W   = 12,
   parameter int MODE_LSB = 8
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctrl_we,
   input  logic [CTRL_W-1:0] ctrl_wdata,
   input  logic              mode_we,
   input  logic [MODE_W-1:0] mode_wdata,
   input  logic              host_wr,
   input  logic [DATA_W-1:0] host_wdata,
   input  logic              line_vld,
   input  logic [DATA_W-1:0] line_data,
   input  logic              line_brk,
   output logic [CTRL_W-1:0] ctrl_rdata,
   output logic [1:0]        chan_mode,
   output logic              rx_en,
   output logic              tx_en,
   output logic              brk_req,
   output logic              rx_rst_pls,
   output logic              tx_rst_pls,
   output logic              tout_rst_pls,
   output logic              rx_push,
   output logic [DATA_W-1:0] rx_push_data,
   output logic              tx_push,
   output logic [DATA_W-1:0] tx_push_data
);

   logic [1:0] dir_en;
   logic [1:0] dir_rst;
   chan_mode_e mode_q;

   uart_ctrl_reg #(.CTRL_W(CTRL_W)) u_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .ctrl_we      (ctrl_we),
      .ctrl_wdata   (ctrl_wdata),
      .ctrl_q       (ctrl_rdata),
      .dir_en       (dir_en),
      .dir_rst_pls  (dir_rst),
      .tout_rst_pls (tout_rst_pls),
      .brk_req      (brk_req)
   );

   uart_path_steer #(.DATA_W(DATA_W), .MODE_W(MODE_W), .MODE_LSB(MODE_LSB)) u_steer (
      .clk          (clk),
      .rst_n        (rst_n),
      .mode_we      (mode_we),
      .mode_wdata   (mode_wdata),
      .dir_en       (dir_en),
      .host_wr      (host_wr),
      .host_wdata   (host_wdata),
      .line_vld     (line_vld),
      .line_data    (line_data),
      .line_brk     (line_brk),
      .mode_q       (mode_q),
      .rx_push      (rx_push),
      .rx_push_data (rx_push_data),
      .tx_push      (tx_push),
      .tx_push_data (tx_push_data)
   );

   assign chan_mode  = mode_q;
   assign rx_en      = dir_en[DIR_RX];
   assign tx_en      = dir_en[DIR_TX];
   assign rx_rst_pls = dir_rst[DIR_RX];
   assign tx_rst_pls = dir_rst[DIR_TX];

   assert_one_rx_src_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_push && $past(line_brk)) |-> rx_push_data == '0);

endmodule

// File: tb/uart_chan_router_test.sv
module uart_chan_router_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ctrl_we = 1'b0;
   logic [8:0] ctrl_wdata = '0;
   logic       mode_we = 1'b0;
   logic [11:0] mode_wdata = '0;
   logic       host_wr = 1'b0;
   logic [7:0] host_wdata = '0;
   logic       line_vld = 1'b0;
   logic [7:0] line_data = '0;
   logic       line_brk = 1'b0;

   logic [8:0] ctrl_rdata;
   logic [1:0] chan_mode;
   logic       rx_en, tx_en, brk_req, rx_rst_pls, tx_rst_pls, tout_rst_pls;
   logic       rx_push, tx_push;
   logic [7:0] rx_push_data, tx_push_data;

   always #2.5 clk = ~clk;

   uart_chan_router uut (
      .clk(clk), .rst_n(rst_n),
      .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
      .mode_we(mode_we), .mode_wdata(mode_wdata),
      .host_wr(host_wr), .host_wdata(host_wdata),
      .line_vld(line_vld), .line_data(line_data), .line_brk(line_brk),
      .ctrl_rdata(ctrl_rdata), .chan_mode(chan_mode),
      .rx_en(rx_en), .tx_en(tx_en), .brk_req(brk_req),
      .rx_rst_pls(rx_rst_pls), .tx_rst_pls(tx_rst_pls), .tout_rst_pls(tout_rst_pls),
      .rx_push(rx_push), .rx_push_data(rx_push_data),
      .tx_push(tx_push), .tx_push_data(tx_push_data)
   );

   // behavioural reference state
   int m_ctrl, m_mode, m_rxp, m_rxd, m_txp, m_txd, m_rr, m_tr, m_to;
   int vectors = 0, miscompares = 0;
   string cur_req = "R1";
   bit done = 0;

   function automatic int bitof(int v, int b);
      return (v >> b) & 1;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_ctrl = 'h128; m_mode = 0;
         m_rxp = 0; m_rxd = 0; m_txp = 0; m_txd = 0;
         m_rr = 0; m_tr = 0; m_to = 0;
      end else begin
         int ren, ten;
         ren = bitof(m_ctrl, 2) && !bitof(m_ctrl, 3);
         ten = bitof(m_ctrl, 4) && !bitof(m_ctrl, 5);
         m_rxp = 0; m_rxd = 0; m_txp = 0; m_txd = 0;
         if (ren) begin
            if (line_brk) m_rxp = 1;
            else if (host_wr && m_mode == 2) begin m_rxp = 1; m_rxd = host_wdata; end
            else if (line_vld && (m_mode == 0 || m_mode == 1)) begin m_rxp = 1; m_rxd = line_data; end
         end
         if (ten) begin
            if (host_wr && m_mode == 0) begin m_txp = 1; m_txd = host_wdata; end
            else if (line_vld && (m_mode == 1 || m_mode == 3)) begin m_txp = 1; m_txd = line_data; end
         end
         m_rr = ctrl_we && ctrl_wdata[0];
         m_tr = ctrl_we && ctrl_wdata[1];
         m_to = ctrl_we && ctrl_wdata[6];
         if (ctrl_we) m_ctrl = ctrl_wdata & 'h1FC;
         if (mode_we) m_mode = (mode_wdata >> 8) & 3;
      end
   end

   task automatic cmp(string f, int act, int exp);
      vectors++;
      if (act != exp) begin
         miscompares++;
         $display("FAIL %s %s: actual %0h expected %0h at %0t", cur_req, f, act, exp, $time);
      end
   endtask

   task automatic tick();
      @(negedge clk);
      cmp("ctrl_rdata", ctrl_rdata, m_ctrl);
      cmp("chan_mode", chan_mode, m_mode);
      cmp("rx_en", rx_en, bitof(m_ctrl, 2) && !bitof(m_ctrl, 3));
      cmp("tx_en", tx_en, bitof(m_ctrl, 4) && !bitof(m_ctrl, 5));
      cmp("brk_req", brk_req, bitof(m_ctrl, 7) && !bitof(m_ctrl, 8));
      cmp("rx_rst_pls", rx_rst_pls, m_rr);
      cmp("tx_rst_pls", tx_rst_pls, m_tr);
      cmp("tout_rst_pls", tout_rst_pls, m_to);
      cmp("rx_push", rx_push, m_rxp);
      if (m_rxp) cmp("rx_push_data", rx_push_data, m_rxd);
      cmp("tx_push", tx_push, m_txp);
      if (m_txp) cmp("tx_push_data", tx_push_data, m_txd);
   endtask

   task automatic idle();
      ctrl_we = 0; mode_we = 0; host_wr = 0; line_vld = 0; line_brk = 0;
   endtask

   task automatic wr_ctrl(int v);
      ctrl_we = 1; ctrl_wdata = v[8:0]; tick(); idle(); tick();
   endtask

   task automatic wr_mode(int v);
      mode_we = 1; mode_wdata = v[11:0]; tick(); idle(); tick();
   endtask

   task automatic stim(bit h, int hd, bit l, int ld, bit b);
      host_wr = h; host_wdata = hd[7:0]; line_vld = l; line_data = ld[7:0]; line_brk = b;
      tick(); idle(); tick();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      cur_req = "R1"; tick(); tick();
      cur_req = "R3"; wr_ctrl('h043); wr_ctrl('h1C3);
      cur_req = "R2"; wr_ctrl('h014); wr_ctrl('h01C); wr_ctrl('h034); wr_ctrl('h03C); wr_ctrl('h014);
      cur_req = "R5"; stim(1, 'hA5, 0, 0, 0); stim(0, 0, 1, 'h3C, 0); stim(1, 'h11, 1, 'h22, 0);
      cur_req = "R11"; wr_mode('hCFF); stim(1, 'h5A, 1, 'h6B, 0); wr_mode('h1300); stim(1, 'h77, 1, 'h88, 0);
      cur_req = "R6"; wr_mode('h100); stim(1, 'h01, 0, 0, 0); stim(0, 0, 1, 'hC3, 0); stim(1, 'h02, 1, 'hE4, 0);
      cur_req = "R7"; wr_mode('h200); stim(1, 'h99, 0, 0, 0); stim(0, 0, 1, 'h44, 0); stim(1, 'h9A, 1, 'h45, 0);
      cur_req = "R8"; wr_mode('h300); stim(1, 'hF0, 0, 0, 0); stim(0, 0, 1, 'h0F, 0); stim(1, 'hF1, 1, 'h1E, 0);
      cur_req = "R10"; stim(0, 0, 0, 0, 1); stim(0, 0, 1, 'h55, 1);
      wr_mode('h000); stim(0, 0, 1, 'hAA, 1);
      wr_mode('h200); stim(1, 'hBB, 0, 0, 1);
      wr_mode('h100); stim(0, 0, 1, 'hCC, 1);
      cur_req = "R9"; wr_ctrl('h018); stim(0, 0, 1, 'h12, 0); stim(0, 0, 0, 0, 1);
      wr_mode('h000); wr_ctrl('h024); stim(1, 'h34, 1, 'h56, 0);
      wr_ctrl('h000); stim(1, 'h78, 1, 'h9A, 1);
      cur_req = "R4"; wr_ctrl('h080); wr_ctrl('h180); wr_ctrl('h100); wr_ctrl('h094);
      cur_req = "R12";
      mode_we = 1; mode_wdata = 12'h200; host_wr = 1; host_wdata = 8'hD1; tick();
      idle(); host_wr = 1; host_wdata = 8'hD2; tick(); idle(); tick();
      ctrl_we = 1; ctrl_wdata = 9'h028; line_vld = 1; line_data = 8'hE1; host_wr = 1; host_wdata = 8'hE2; tick();
      idle(); host_wr = 1; host_wdata = 8'hE3; tick(); idle(); tick();
      for (int i = 0; i < 400; i++) begin
         ctrl_we    = ($urandom % 8) == 0;
         ctrl_wdata = 9'($urandom);
         mode_we    = ($urandom % 6) == 0;
         mode_wdata = 12'($urandom);
         host_wr    = $urandom % 2;
         host_wdata = 8'($urandom);
         line_vld   = $urandom % 2;
         line_data  = 8'($urandom);
         line_brk   = ($urandom % 7) == 0;
         tick();
      end
      idle(); tick();
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         miscompares++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

endmodule